// File: doc/BRIEF.md
# Mode-Selectable Peripheral Clock Tree

The block turns one master clock into a set of single-cycle enable strobes that pace the slower peripherals: a bus strobe, a UART strobe, an SPI reference strobe, a programmable SPI strobe, a PWM strobe and a timer reference strobe. Every strobe sits in the master clock domain. The master clock stands for the selected core rate. Each divide ratio is therefore a count of master-clock cycles, and each ratio depends on the clock mode.

The `ext_mode` input chooses between two sources. When it is high, the core runs from the fixed crystal path and the PLL counts as off. When it is low, the core runs from the PLL. The PLL rate is set by an 8-bit multiplier that software writes. The multiplier is checked against a legal range, and a configured fallback value replaces it when it is out of range. In PLL mode the bus strobe follows one of two rules. Above the knee multiplier it is half the core rate. At or below the knee it is held at a fixed absolute rate by a fractional accumulator.

A write port loads two staged registers: the PLL multiplier and a control word holding the SPI divide select and the timer select. A staged value takes effect only at the next terminal strobe of the divider it drives. A change of `ext_mode` clears every counter and starts all of them again together.

Top module: `pclk_tree`

## Requirements
- R1: While reset is asserted and for the two synchronising cycles after its release, every enable strobe is low and `pll_on` is high.
- R2: With `ext_mode` held high, `en_bus` is high on every cycle. `en_spi_ref` pulses once every 96 cycles and `en_pwm` once every 128 cycles.
- R3: With `ext_mode` high, `en_tim` pulses once every 24 cycles when control bit 0 is 0, and once every 26 cycles when control bit 0 is 1.
- R4: With `ext_mode` held low, `en_spi_ref` pulses once every 576 cycles, `en_pwm` once every 768 cycles and `en_tim` once every 144 cycles.
- R5: In PLL mode with an effective multiplier above 20, `en_bus` pulses on every second cycle.
- R6: In PLL mode with an effective multiplier M of 20 or less, `en_bus` pulses 10 times in every M cycles. It pulses on every cycle when M is 10 or less.
- R7: A write with `wr_sel`=0 loads the multiplier from `wr_data[31:24]`. A value from 10 to 50 inclusive is used as is. Any other value is replaced by FALLBACK_MULT (default 40), unless FALLBACK_MULT is 0, in which case the raw value is used.
- R8: A write with `wr_sel`=1 loads the SPI select from `wr_data[17:16]`. `en_spi` pulses once every 32, 8, 2 or 1 `en_spi_ref` pulses for select values 0, 1, 2 and 3, and it only ever pulses together with `en_spi_ref`.
- R9: `en_uart` pulses once every 10 `en_bus` pulses, and only together with `en_bus`.
- R10: In the cycle after `ext_mode` changes, every strobe is low. All dividers then restart their periods from zero.
- R11: A staged register value takes effect at the next terminal strobe of the divider it drives, so the period in progress keeps its old length.
- R12: `pll_on` is the inverse of `ext_mode`, registered once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_mode | input | 1 | 1 selects the fixed crystal path, 0 selects the PLL path |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = PLL multiplier register, 1 = control register |
| wr_data | input | 32 | Write data |
| pll_on | output | 1 | High while the PLL path is in use |
| en_bus | output | 1 | Bus enable strobe |
| en_uart | output | 1 | UART enable strobe |
| en_spi_ref | output | 1 | SPI reference enable strobe |
| en_spi | output | 1 | Programmable SPI enable strobe |
| en_pwm | output | 1 | PWM enable strobe |
| en_tim | output | 1 | Timer reference enable strobe |

## Verification
The bench runs the PLL path with the multiplier at several values. In-range values of 10, 12 and 15 produce three different fractional bus rates. Out-of-range values of 9 and 60 produce the same half-rate bus as the default fallback, which is how the range check is seen. In the crystal path both timer selects are tried, and the SPI select is stepped through 3, 2 and 1. The select is then changed right after an SPI strobe, so the next interval shows whether the old period ran to its end. The mode is switched in both directions, which shows the quiet restart cycle. A behavioural model checked on every clock catches any single-cycle phase slip that a rate count over a window would miss.

// File: rtl/pclk_tree_pkg.sv
package pclk_tree_pkg;

  localparam int MULT_W = 8;
  localparam int SPI_CW = 5;

  // Effective multiplier after the legal-range check.
  function automatic logic [MULT_W-1:0] eff_mult(input logic [MULT_W-1:0] raw,
                                                 input int lo, input int hi,
                                                 input int fb);
    if (((int'(raw) >= lo) && (int'(raw) <= hi)) || (fb == 0))
      return raw;
    return MULT_W'(fb);
  endfunction

  // Terminal count of the SPI divider for each select code.
  function automatic logic [SPI_CW-1:0] spi_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return SPI_CW'(31);
      2'd1:    return SPI_CW'(7);
      2'd2:    return SPI_CW'(1);
      default: return SPI_CW'(0);
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pct_divider.sv
module pct_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = step && !restart && (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (step)
      cnt_d = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pct_bus_gen.sv
module pct_bus_gen #(
  parameter int MW   = 8,
  parameter int KNEE = 20,
  parameter int NUM  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          clr,
  input  logic          ext,
  input  logic [MW-1:0] mult,
  output logic          tick
);

  logic          phase_q, phase_d;
  logic [MW-1:0] acc_q, acc_d;
  logic [MW:0]   sum;
  logic          frac;

  assign sum  = {1'b0, acc_q} + (MW+1)'(NUM);
  assign frac = !ext && (mult > MW'(NUM)) && (mult <= MW'(KNEE));

  always_comb begin
    if (restart)                tick = 1'b0;
    else if (ext)               tick = 1'b1;
    else if (mult > MW'(KNEE))  tick = phase_q;
    else if (!frac)             tick = 1'b1;
    else                        tick = (sum >= {1'b0, mult});
  end

  always_comb begin
    phase_d = ~phase_q;
    acc_d   = '0;
    if (frac)
      acc_d = (sum >= {1'b0, mult}) ? MW'(sum - {1'b0, mult}) : MW'(sum);
    if (restart || clr) begin
      phase_d = 1'b0;
      acc_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
    end
  end

endmodule

// File: rtl/pclk_tree.sv
module pclk_tree
  import pclk_tree_pkg::*;
#(
  parameter int EXT_SPI_DIV   = 96,
  parameter int EXT_PWM_DIV   = 128,
  parameter int EXT_TIM_DIV_A = 24,
  parameter int EXT_TIM_DIV_B = 26,
  parameter int PLL_SPI_DIV   = 576,
  parameter int PLL_PWM_DIV   = 768,
  parameter int PLL_TIM_DIV   = 144,
  parameter int MULT_LO       = 10,
  parameter int MULT_HI       = 50,
  parameter int MULT_KNEE     = 20,
  parameter int BUS_NUM       = 10,
  parameter int FALLBACK_MULT = 40,
  parameter int UART_DIV      = 10,
  parameter int TSEL_BIT      = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic        pll_on,
  output logic        en_bus,
  output logic        en_uart,
  output logic        en_spi_ref,
  output logic        en_spi,
  output logic        en_pwm,
  output logic        en_tim
);

  localparam int CW = $clog2(max3(max3(EXT_SPI_DIV, EXT_PWM_DIV, EXT_TIM_DIV_A),
                                  max3(EXT_TIM_DIV_B, PLL_SPI_DIV, PLL_PWM_DIV),
                                  PLL_TIM_DIV) + 1);
  localparam int UW = $clog2(UART_DIV + 1);
  localparam int NPD = 3;  // spi_ref, pwm, tim
  localparam logic [MULT_W-1:0] MULT_RST = eff_mult('0, MULT_LO, MULT_HI, FALLBACK_MULT);

  // Reset synchroniser: asserts at once, releases on the clock
  logic rs_a, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a    <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rs_a    <= 1'b1;
      rst_n_i <= rs_a;
    end
  end

  // Mode tracking
  logic mode_q;
  logic restart;
  assign restart = (ext_mode != mode_q);
  assign pll_on  = ~mode_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) mode_q <= 1'b0;
    else          mode_q <= ext_mode;
  end

  // Staged register fields
  logic [MULT_W-1:0] mult_pend_q, mult_pend_d;
  logic [1:0]        spis_pend_q, spis_pend_d;
  logic              tims_pend_q, tims_pend_d;

  always_comb begin
    mult_pend_d = mult_pend_q;
    spis_pend_d = spis_pend_q;
    tims_pend_d = tims_pend_q;
    if (wr_en && !wr_sel) mult_pend_d = wr_data[31:24];
    if (wr_en &&  wr_sel) begin
      spis_pend_d = wr_data[17:16];
      tims_pend_d = wr_data[TSEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mult_pend_q <= '0;
      spis_pend_q <= '0;
      tims_pend_q <= 1'b0;
    end else begin
      mult_pend_q <= mult_pend_d;
      spis_pend_q <= spis_pend_d;
      tims_pend_q <= tims_pend_d;
    end
  end

  logic [MULT_W-1:0] mult_eff_pend;
  assign mult_eff_pend = eff_mult(mult_pend_q, MULT_LO, MULT_HI, FALLBACK_MULT);

  // Active settings
  logic [MULT_W-1:0] mult_act_q, mult_act_d;
  logic [1:0]        spis_act_q, spis_act_d;
  logic              tims_act_q, tims_act_d;

  // Peripheral dividers from the core rate
  logic [CW-1:0]  pd_last [NPD];
  logic [NPD-1:0] pd_tick;

  always_comb begin
    pd_last[0] = ext_mode ? CW'(EXT_SPI_DIV - 1) : CW'(PLL_SPI_DIV - 1);
    pd_last[1] = ext_mode ? CW'(EXT_PWM_DIV - 1) : CW'(PLL_PWM_DIV - 1);
    if (!ext_mode)       pd_last[2] = CW'(PLL_TIM_DIV - 1);
    else if (tims_act_q) pd_last[2] = CW'(EXT_TIM_DIV_B - 1);
    else                 pd_last[2] = CW'(EXT_TIM_DIV_A - 1);
  end

  for (genvar g = 0; g < NPD; g++) begin : g_pd
    pct_divider #(.W(CW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .restart (restart),
      .step    (1'b1),
      .last    (pd_last[g]),
      .tick    (pd_tick[g])
    );
  end

  // Programmable SPI divider on the SPI reference
  logic spi_tick;
  pct_divider #(.W(SPI_CW)) u_spi (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .restart (restart),
    .step    (pd_tick[0]),
    .last    (spi_last(spis_act_q)),
    .tick    (spi_tick)
  );

  // Bus rate and UART
  logic bus_tick, bus_clr, uart_tick;
  assign bus_clr = bus_tick && (mult_eff_pend != mult_act_q);

  pct_bus_gen #(.MW(MULT_W), .KNEE(MULT_KNEE), .NUM(BUS_NUM)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .restart (restart),
    .clr     (bus_clr),
    .ext     (ext_mode),
    .mult    (mult_act_q),
    .tick    (bus_tick)
  );

  pct_divider #(.W(UW)) u_uart (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .restart (restart),
    .step    (bus_tick),
    .last    (UW'(UART_DIV - 1)),
    .tick    (uart_tick)
  );

  // Staged values move to active at terminal strobes
  always_comb begin
    mult_act_d = mult_act_q;
    spis_act_d = spis_act_q;
    tims_act_d = tims_act_q;
    if (restart) begin
      mult_act_d = mult_eff_pend;
      spis_act_d = spis_pend_q;
      tims_act_d = tims_pend_q;
    end else begin
      if (bus_tick)   mult_act_d = mult_eff_pend;
      if (spi_tick)   spis_act_d = spis_pend_q;
      if (pd_tick[2]) tims_act_d = tims_pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mult_act_q <= MULT_RST;
      spis_act_q <= '0;
      tims_act_q <= 1'b0;
    end else begin
      mult_act_q <= mult_act_d;
      spis_act_q <= spis_act_d;
      tims_act_q <= tims_act_d;
    end
  end

  // Registered strobes
  logic [5:0] strb_q, strb_d;
  assign strb_d = {bus_tick, uart_tick, pd_tick[0], spi_tick, pd_tick[1], pd_tick[2]};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) strb_q <= '0;
    else          strb_q <= strb_d;
  end

  assign {en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim} = strb_q;

endmodule

// File: rtl/pclk_tree_chk.sv
module pclk_tree_chk (
  input logic clk,
  input logic rst_i,
  input logic ext_mode,
  input logic mode_q,
  input logic pll_on,
  input logic en_bus,
  input logic en_uart,
  input logic en_spi_ref,
  input logic en_spi,
  input logic en_pwm,
  input logic en_tim
);

  p_spi_in_ref_r8: assert property (@(posedge clk) disable iff (!rst_i)
    en_spi |-> en_spi_ref);

  p_uart_in_bus_r9: assert property (@(posedge clk) disable iff (!rst_i)
    en_uart |-> en_bus);

  p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (ext_mode != mode_q) |=>
      !(en_bus || en_uart || en_spi_ref || en_spi || en_pwm || en_tim));

  p_ext_bus_every_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q && $past(mode_q)) |-> en_bus);

  p_tim_gap_r3: assert property (@(posedge clk) disable iff (!rst_i)
    en_tim |=> !en_tim);

  p_pll_on_r12: assert property (@(posedge clk) disable iff (!rst_i)
    !$isunknown(ext_mode) |=> (pll_on == !$past(ext_mode)));

endmodule

bind pclk_tree pclk_tree_chk u_chk (
  .clk        (clk),
  .rst_i      (rst_n_i),
  .ext_mode   (ext_mode),
  .mode_q     (mode_q),
  .pll_on     (pll_on),
  .en_bus     (en_bus),
  .en_uart    (en_uart),
  .en_spi_ref (en_spi_ref),
  .en_spi     (en_spi),
  .en_pwm     (en_pwm),
  .en_tim     (en_tim)
);

// File: tb/pclk_tree_bench.sv
`timescale 1ns/1ps
module pclk_tree_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_mode;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic        pll_on, en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim;

  always #10 clk = ~clk;  // 50 MHz

  pclk_tree u_pclk_tree (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pll_on(pll_on), .en_bus(en_bus), .en_uart(en_uart),
    .en_spi_ref(en_spi_ref), .en_spi(en_spi), .en_pwm(en_pwm), .en_tim(en_tim)
  );

  int    errors = 0;
  int    checks = 0;
  string ph = "R1";
  bit    done = 0;

  // ---------------- behavioural reference model ----------------
  int m_rs1, m_rs2, m_modeq, m_praw, m_spip, m_timp, m_mult, m_spis, m_tims;
  int c_ref, c_pwm, c_tim, c_spi, c_uart, b_ph, b_acc;
  bit e_bus, e_uart, e_ref, e_spi, e_pwm, e_tim, e_pll;

  function automatic int effm(int raw);
    if ((raw >= 10 && raw <= 50)) return raw;
    return 40;
  endfunction

  task automatic m_clear();
    m_modeq = 0; m_praw = 0; m_spip = 0; m_timp = 0;
    m_mult = effm(0); m_spis = 0; m_tims = 0;
    c_ref = 0; c_pwm = 0; c_tim = 0; c_spi = 0; c_uart = 0; b_ph = 0; b_acc = 0;
    {e_bus, e_uart, e_ref, e_spi, e_pwm, e_tim} = '0;
    e_pll = 1;
  endtask

  task automatic m_step();
    int pref, ppwm, ptim, pspi, effp;
    bit ex, t_ref, t_pwm, t_tim, t_b, t_spi, t_u, frac;
    ex = ext_mode;
    effp = effm(m_praw);
    if (int'(ex) != m_modeq) begin
      c_ref = 0; c_pwm = 0; c_tim = 0; c_spi = 0; c_uart = 0; b_ph = 0; b_acc = 0;
      m_spis = m_spip; m_tims = m_timp; m_mult = effp;
      {e_bus, e_uart, e_ref, e_spi, e_pwm, e_tim} = '0;
    end else begin
      pref = ex ? 96 : 576;
      ppwm = ex ? 128 : 768;
      ptim = ex ? (m_tims ? 26 : 24) : 144;
      t_ref = (c_ref == pref - 1); c_ref = t_ref ? 0 : c_ref + 1;
      t_pwm = (c_pwm == ppwm - 1); c_pwm = t_pwm ? 0 : c_pwm + 1;
      t_tim = (c_tim == ptim - 1); c_tim = t_tim ? 0 : c_tim + 1;
      if (t_tim) m_tims = m_timp;
      frac = !ex && m_mult > 10 && m_mult <= 20;
      if (ex) t_b = 1;
      else if (m_mult > 20) t_b = (b_ph == 1);
      else if (!frac) t_b = 1;
      else t_b = (b_acc + 10 >= m_mult);
      if (t_b && effp != m_mult) begin
        b_ph = 0; b_acc = 0; m_mult = effp;
      end else begin
        b_ph = 1 - b_ph;
        if (frac) b_acc = (b_acc + 10 >= m_mult) ? b_acc + 10 - m_mult : b_acc + 10;
        else b_acc = 0;
      end
      pspi = (m_spis == 0) ? 32 : (m_spis == 1) ? 8 : (m_spis == 2) ? 2 : 1;
      t_spi = 0;
      if (t_ref) begin
        t_spi = (c_spi >= pspi - 1);
        c_spi = t_spi ? 0 : c_spi + 1;
        if (t_spi) m_spis = m_spip;
      end
      t_u = 0;
      if (t_b) begin
        t_u = (c_uart == 9);
        c_uart = t_u ? 0 : c_uart + 1;
      end
      e_bus = t_b; e_uart = t_u; e_ref = t_ref; e_spi = t_spi; e_pwm = t_pwm; e_tim = t_tim;
    end
    m_modeq = ex;
    e_pll = !ex;
    if (wr_en) begin
      if (!wr_sel) m_praw = wr_data[31:24];
      else begin m_spip = wr_data[17:16]; m_timp = wr_data[0]; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_clear();
    end else begin
      int old;
      old = m_rs2; m_rs2 = m_rs1; m_rs1 = 1;
      if (old == 0) m_clear();
      else m_step();
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    logic [6:0] act, exp;
    act = {pll_on, en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim};
    exp = {e_pll, e_bus, e_uart, e_ref, e_spi, e_pwm, e_tim};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s model compare at %0t: actual=%b expected=%b", ph, $time, act, exp);
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++; checks++;
      $display("FAIL %s watchdog: actual=%0d cycles expected=<190000", ph, cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  function automatic bit pick(int s);
    case (s)
      0: return en_bus;
      1: return en_uart;
      2: return en_spi_ref;
      3: return en_spi;
      4: return en_pwm;
      default: return en_tim;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic rate(int s, int win, int exp, string tag, string what);
    int n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      n += pick(s);
    end
    check(tag, n, exp, what);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic quiet_check(string tag);
    @(negedge clk);
    check(tag, {en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim}, 0, "strobes after mode change");
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; ext_mode = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    ph = "R1";
    idle(3);
    check("R1", {en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim}, 0, "strobes in reset");
    check("R1", pll_on, 1, "pll_on in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", {en_bus, en_uart, en_spi_ref, en_spi, en_pwm, en_tim}, 0, "strobes during sync");
    idle(10);

    ph = "R4";
    rate(2, 1152, 2, "R4", "pll spi_ref /576");
    rate(4, 1536, 2, "R4", "pll pwm /768");
    rate(5, 288, 2, "R4", "pll tim /144");
    ph = "R5";
    rate(0, 100, 50, "R5", "bus half rate with fallback 40");
    ph = "R9";
    rate(1, 200, 10, "R9", "uart bus/10");

    ph = "R6";
    wr(0, 32'h0F00_0000); idle(20);
    rate(0, 30, 20, "R6", "bus with mult 15");
    rate(1, 150, 10, "R9", "uart with mult 15");
    wr(0, 32'h0A00_0000); idle(20);
    rate(0, 50, 50, "R6", "bus with mult 10");
    ph = "R7";
    wr(0, 32'h0900_0000); idle(20);
    rate(0, 100, 50, "R7", "bus with mult 9 -> fallback");
    wr(0, 32'h0C00_0000); idle(20);
    rate(0, 60, 50, "R6", "bus with mult 12");
    wr(0, 32'h3C00_0000); idle(20);
    rate(0, 100, 50, "R7", "bus with mult 60 -> fallback");

    ph = "R10";
    ext_mode = 1;
    quiet_check("R10");
    check("R12", pll_on, 0, "pll_on in crystal mode");
    ph = "R2";
    idle(5);
    rate(0, 50, 50, "R2", "ext bus every cycle");
    rate(2, 192, 2, "R2", "ext spi_ref /96");
    rate(4, 256, 2, "R2", "ext pwm /128");
    ph = "R3";
    rate(5, 48, 2, "R3", "ext tim /24");
    wr(1, 32'h0000_0001); idle(60);
    rate(5, 52, 2, "R3", "ext tim /26");

    ph = "R8";
    wr(1, 32'h0003_0001); idle(3200);
    rate(3, 192, 2, "R8", "spi sel3 /1");
    wr(1, 32'h0002_0001); idle(200);
    rate(3, 384, 2, "R8", "spi sel2 /2");
    wr(1, 32'h0001_0001); idle(300);
    rate(3, 1536, 2, "R8", "spi sel1 /8");

    ph = "R11";
    begin
      int n;
      do @(negedge clk); while (!en_spi);
      wr(1, 32'h0003_0001);
      n = 1;
      while (!en_spi) begin @(negedge clk); n++; end
      check("R11", n, 768, "interval in progress keeps old select");
      n = 0;
      do begin @(negedge clk); n++; end while (!en_spi);
      check("R11", n, 96, "next interval uses new select");
    end

    ph = "R10";
    ext_mode = 0;
    quiet_check("R10");
    check("R12", pll_on, 1, "pll_on back in pll mode");
    ph = "R4";
    idle(5);
    rate(5, 288, 2, "R4", "pll tim after return");
    rate(3, 1152, 2, "R8", "pll spi sel3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule